// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block drives a small I2C master data engine whose buffer holds at most four bytes per command. A requester hands it one message at a time: a byte length, a direction, a target address in 7-bit or 10-bit form, and a flag saying that another message to the same target follows without releasing the bus. The sequencer cuts the message into pieces of one to four bytes. For each piece it fills the engine buffer from the requester's write stream, or empties it into the requester's read stream. It issues one command per piece and then checks the byte count the engine reports back.

Pieces that are not the last one ask the engine to keep the bus. The last piece of a message that has a follower asks for a repeated start instead of a stop. Bad requests, a busy bus, a short count and a hung engine each end the message with their own error code. The cases that leave the engine mid-transfer also send it an abort. The engine itself sits outside the block.

Top module: `i2c_chunk_sequencer`

## Requirements
- R1: A message of L bytes (1 to 255) produces exactly (L+3)/4 commands. Command k carries min(L-4k, 4) bytes, written in `engCmdCount` as that byte count minus one (2'b11 means four bytes).
- R2: `engCmdChain` is 1 on every command except the last of the message, and 0 on the last.
- R3: `engCmdRepStart` is 1 only on the last command of a message requested with `reqCombined`=1. It is never 1 together with `engCmdChain`.
- R4: For writes, every byte of a piece is taken from `txByte` and written into the engine buffer, in stream order, before that piece's command. For reads, the piece's bytes go out on `rxByte`/`rxPush` in order, and only after the engine reports a matching count.
- R5: On `engAddrLoad`, a 7-bit target gives `engAddrLo` = addr<<1, `engAddrHi` = 0 and `engAddrMode` = 0. A 10-bit target gives `engAddrLo` = addr[7:0], `engAddrHi` = 8'hF0 | ((addr>>7) & 8'h06) and `engAddrMode` = 1.
- R6: A length of zero, a 7-bit address above 0x7F, or a message that follows a combined one but has a different address or address mode ends with `errCode` 1. It issues no command, no flush and no abort, and it ends the combined run.
- R7: A message that does not continue a combined run needs `engBusFree`=1, or it ends with `errCode` 2 and issues no command. When the bus is free, one `engFlush` and one `engAddrLoad` come before the first command. A message that continues a run skips the bus check, the flush and the address load.
- R8: When the engine reports a count that differs from the piece's count, the message ends with `errCode` 3. No further piece is issued and the short piece's read bytes are not unloaded. `engAbort` pulses only when the piece was not the last one or the message is combined.
- R9: When no `engDone` arrives within TMO_CYCLES cycles of a command, `engAbort` pulses and the message ends with `errCode` 4. An `engDone` that arrives in the last cycle of the window still counts as a completion.
- R10: After reset, `done`, `errCode` and every engine and stream strobe are 0. `done` pulses for one cycle per accepted `start`, with `errCode` valid in that cycle (0 meaning success).

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| reqLen | input | LEN_W | Message length in bytes |
| reqRead | input | 1 | 1 = read message |
| reqAddr | input | 10 | Target address |
| reqTenBit | input | 1 | 1 = 10-bit address |
| reqCombined | input | 1 | Another message to the same target follows |
| txByte | input | 8 | Next write byte from the requester |
| txPop | output | 1 | Consumes `txByte` |
| rxByte | output | 8 | Read byte to the requester |
| rxPush | output | 1 | `rxByte` valid |
| done | output | 1 | Message finished |
| errCode | output | 3 | 0 ok, 1 bad request, 2 bus busy, 3 short count, 4 timeout |
| engFlush | output | 1 | Flush engine buffer |
| engAddrLoad | output | 1 | Load target address registers |
| engAddrLo | output | 8 | Low address byte |
| engAddrHi | output | 8 | High address byte |
| engAddrMode | output | 1 | 10-bit address mode |
| engBufWrite | output | 1 | Write one byte to engine buffer |
| engBufWData | output | 8 | Byte written to the buffer |
| engBufRead | output | 1 | Read one byte from engine buffer |
| engBufRData | input | 8 | Byte read from the buffer |
| engCmdValid | output | 1 | Command pulse |
| engCmdCount | output | 2 | Piece byte count minus one |
| engCmdRead | output | 1 | Command direction |
| engCmdChain | output | 1 | Keep bus after this piece |
| engCmdRepStart | output | 1 | Repeated start after this piece |
| engDone | input | 1 | Engine completion pulse |
| engXferCount | input | 3 | Bytes the engine actually moved |
| engAbort | output | 1 | Abort pulse to engine |
| engBusFree | input | 1 | Engine reports bus idle |

## Verification
The completion pulse and the expiry of the per-piece timeout can land in the same cycle. The bench provokes this by having its engine responder answer exactly TMO_CYCLES cycles after a command, and then one cycle later. In the first case the message must finish with code 0 and no abort. In the second it must finish with code 4, with one abort and only one command issued.

// File: rtl/i2c_chunk_pkg.sv
package i2c_chunk_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ARG   = 3'd1,
    ERR_BUS   = 3'd2,
    ERR_SHORT = 3'd3,
    ERR_TMO   = 3'd4
  } seqErr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PREP, S_LOAD, S_ISSUE, S_WAIT, S_UNLOAD, S_ABORT, S_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldMsg;
    logic ldChunk;
    logic byteStep;
    logic tmrClr;
    logic tmrStep;
    logic runSet;
    logic runClr;
  } seqCtl_t;

endpackage

// File: rtl/i2c_chunk_dp.sv
module i2c_chunk_dp
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int TMO_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqRead,
  input  logic [9:0]       reqAddr,
  input  logic             reqTenBit,
  input  logic             reqCombined,
  input  logic [2:0]       engXferCount,
  output logic             msgRead,
  output logic             msgComb,
  output logic             argBad,
  output logic             runActive,
  output logic             chunkLast,
  output logic             byteLast,
  output logic             tmrExpired,
  output logic             countOk,
  output logic [1:0]       cmdCount,
  output logic [7:0]       addrLo,
  output logic [7:0]       addrHi,
  output logic             addrMode
);

  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  localparam logic [LEN_W-1:0] PIECE_MAX = LEN_W'(4);
  localparam logic [9:0] ADDR7_MAX = 10'h07F;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

  logic [LEN_W-1:0] lenQ, remQ;
  logic [9:0]       addrQ, runAddrQ;
  logic             readQ, tenQ, combQ, runActQ, runTenQ, lastQ;
  logic [2:0]       cntQ, byteIdxQ;
  logic [TMO_W-1:0] tmrQ;
  logic [2:0]       pieceNow;

  assign pieceNow = (remQ > PIECE_MAX) ? 3'd4 : remQ[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ     <= '0;
      remQ     <= '0;
      addrQ    <= '0;
      readQ    <= 1'b0;
      tenQ     <= 1'b0;
      combQ    <= 1'b0;
      cntQ     <= '0;
      lastQ    <= 1'b0;
      byteIdxQ <= '0;
    end else begin
      if (ctl.ldMsg) begin
        lenQ  <= reqLen;
        remQ  <= reqLen;
        addrQ <= reqAddr;
        readQ <= reqRead;
        tenQ  <= reqTenBit;
        combQ <= reqCombined;
      end
      if (ctl.ldChunk) begin
        cntQ     <= pieceNow;
        lastQ    <= (remQ <= PIECE_MAX);
        remQ     <= remQ - LEN_W'(pieceNow);
        byteIdxQ <= '0;
      end else if (ctl.byteStep) begin
        byteIdxQ <= byteIdxQ + 3'd1;
      end
    end
  end

  // combined-run memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runActQ  <= 1'b0;
      runAddrQ <= '0;
      runTenQ  <= 1'b0;
    end else if (ctl.runSet) begin
      runActQ  <= 1'b1;
      runAddrQ <= addrQ;
      runTenQ  <= tenQ;
    end else if (ctl.runClr) begin
      runActQ  <= 1'b0;
    end
  end

  // per-piece completion timer
  always_ff @(posedge clk) begin
    if (!rstN)            tmrQ <= '0;
    else if (ctl.tmrClr)  tmrQ <= '0;
    else if (ctl.tmrStep) tmrQ <= tmrQ + TMO_W'(1);
  end

  assign msgRead    = readQ;
  assign msgComb    = combQ;
  assign runActive  = runActQ;
  assign chunkLast  = lastQ;
  assign byteLast   = (byteIdxQ == (cntQ - 3'd1));
  assign tmrExpired = (tmrQ == TMO_LAST);
  assign countOk    = (engXferCount == cntQ);
  assign cmdCount   = cntQ[1:0] - 2'd1;

  assign argBad = (lenQ == '0)
               || (!tenQ && (addrQ > ADDR7_MAX))
               || (runActQ && ((addrQ != runAddrQ) || (tenQ != runTenQ)));

  assign addrLo   = tenQ ? addrQ[7:0] : {addrQ[6:0], 1'b0};
  assign addrHi   = tenQ ? {5'b11110, addrQ[9:8], 1'b0} : 8'h00;
  assign addrMode = tenQ;

endmodule

// File: rtl/i2c_chunk_ctl.sv
module i2c_chunk_ctl
  import i2c_chunk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       argBad,
  input  logic       runActive,
  input  logic       busFree,
  input  logic       msgRead,
  input  logic       msgComb,
  input  logic       chunkLast,
  input  logic       byteLast,
  input  logic       tmrExpired,
  input  logic       countOk,
  input  logic       engDone,
  output seqCtl_t    ctl,
  output logic       bufWrite,
  output logic       bufRead,
  output logic       cmdValid,
  output logic       flush,
  output logic       addrLoad,
  output logic       abort,
  output logic       done,
  output logic [2:0] errCode
);

  seqState_t stateQ, stateD;
  seqErr_t   errQ, errD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      errQ   <= ERR_NONE;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  always_comb begin
    stateD   = stateQ;
    errD     = errQ;
    ctl      = '0;
    bufWrite = 1'b0;
    bufRead  = 1'b0;
    cmdValid = 1'b0;
    flush    = 1'b0;
    addrLoad = 1'b0;
    abort    = 1'b0;
    done     = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.ldMsg = 1'b1;
          errD      = ERR_NONE;
          stateD    = S_CHECK;
        end
      end
      S_CHECK: begin
        if (argBad) begin
          errD   = ERR_ARG;
          stateD = S_FINISH;
        end else if (runActive) begin
          stateD = S_PREP;
        end else if (!busFree) begin
          errD   = ERR_BUS;
          stateD = S_FINISH;
        end else begin
          flush    = 1'b1;
          addrLoad = 1'b1;
          stateD   = S_PREP;
        end
      end
      S_PREP: begin
        ctl.ldChunk = 1'b1;
        stateD      = msgRead ? S_ISSUE : S_LOAD;
      end
      S_LOAD: begin
        bufWrite     = 1'b1;
        ctl.byteStep = 1'b1;
        if (byteLast) stateD = S_ISSUE;
      end
      S_ISSUE: begin
        cmdValid   = 1'b1;
        ctl.tmrClr = 1'b1;
        stateD     = S_WAIT;
      end
      S_WAIT: begin
        ctl.tmrStep = 1'b1;
        if (engDone) begin
          if (countOk) begin
            if (msgRead)        stateD = S_UNLOAD;
            else if (chunkLast) stateD = S_FINISH;
            else                stateD = S_PREP;
          end else begin
            errD   = ERR_SHORT;
            stateD = (!chunkLast || msgComb) ? S_ABORT : S_FINISH;
          end
        end else if (tmrExpired) begin
          errD   = ERR_TMO;
          stateD = S_ABORT;
        end
      end
      S_UNLOAD: begin
        bufRead      = 1'b1;
        ctl.byteStep = 1'b1;
        if (byteLast) stateD = chunkLast ? S_FINISH : S_PREP;
      end
      S_ABORT: begin
        abort  = 1'b1;
        stateD = S_FINISH;
      end
      S_FINISH: begin
        done = 1'b1;
        if (errQ == ERR_NONE && msgComb) ctl.runSet = 1'b1;
        else                             ctl.runClr = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign errCode = errQ;

endmodule

// File: rtl/i2c_chunk_sequencer.sv
module i2c_chunk_sequencer
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int TMO_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqRead,
  input  logic [9:0]       reqAddr,
  input  logic             reqTenBit,
  input  logic             reqCombined,
  input  logic [7:0]       txByte,
  output logic             txPop,
  output logic [7:0]       rxByte,
  output logic             rxPush,
  output logic             done,
  output logic [2:0]       errCode,
  output logic             engFlush,
  output logic             engAddrLoad,
  output logic [7:0]       engAddrLo,
  output logic [7:0]       engAddrHi,
  output logic             engAddrMode,
  output logic             engBufWrite,
  output logic [7:0]       engBufWData,
  output logic             engBufRead,
  input  logic [7:0]       engBufRData,
  output logic             engCmdValid,
  output logic [1:0]       engCmdCount,
  output logic             engCmdRead,
  output logic             engCmdChain,
  output logic             engCmdRepStart,
  input  logic             engDone,
  input  logic [2:0]       engXferCount,
  output logic             engAbort,
  input  logic             engBusFree
);

  seqCtl_t ctl;
  logic msgRead, msgComb, argBad, runActive, chunkLast, byteLast, tmrExpired, countOk;
  logic bufWrite, bufRead;

  i2c_chunk_dp #(.LEN_W(LEN_W), .TMO_CYCLES(TMO_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqLen(reqLen), .reqRead(reqRead), .reqAddr(reqAddr),
    .reqTenBit(reqTenBit), .reqCombined(reqCombined),
    .engXferCount(engXferCount),
    .msgRead(msgRead), .msgComb(msgComb), .argBad(argBad), .runActive(runActive),
    .chunkLast(chunkLast), .byteLast(byteLast), .tmrExpired(tmrExpired),
    .countOk(countOk), .cmdCount(engCmdCount),
    .addrLo(engAddrLo), .addrHi(engAddrHi), .addrMode(engAddrMode)
  );

  i2c_chunk_ctl ctl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .argBad(argBad), .runActive(runActive), .busFree(engBusFree),
    .msgRead(msgRead), .msgComb(msgComb), .chunkLast(chunkLast),
    .byteLast(byteLast), .tmrExpired(tmrExpired), .countOk(countOk),
    .engDone(engDone), .ctl(ctl),
    .bufWrite(bufWrite), .bufRead(bufRead), .cmdValid(engCmdValid),
    .flush(engFlush), .addrLoad(engAddrLoad), .abort(engAbort),
    .done(done), .errCode(errCode)
  );

  assign engBufWrite    = bufWrite;
  assign txPop          = bufWrite;
  assign engBufWData    = txByte;
  assign engBufRead     = bufRead;
  assign rxPush         = bufRead;
  assign rxByte         = engBufRData;
  assign engCmdRead     = msgRead;
  assign engCmdChain    = !chunkLast;
  assign engCmdRepStart = chunkLast && msgComb;

endmodule

// File: rtl/i2c_chunk_sequencer_chk.sv
module i2c_chunk_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic [2:0] errCode,
  input logic       engCmdValid,
  input logic       engCmdChain,
  input logic       engCmdRepStart,
  input logic       engCmdRead,
  input logic       engBufWrite,
  input logic       engBufRead,
  input logic       engFlush,
  input logic       engBusFree,
  input logic       engAbort
);

  p_chain_rep_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> !(engCmdChain && engCmdRepStart));

  p_single_cmd_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |=> !engCmdValid);

  p_write_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    engBufWrite |-> !engCmdRead);

  p_read_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    engBufRead |-> engCmdRead);

  p_flush_bus_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    engFlush |-> engBusFree);

  p_timeout_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == 3'd4) |-> $past(engAbort));

  p_no_cmd_at_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !engCmdValid && !engBufWrite && !engBufRead);

endmodule

bind i2c_chunk_sequencer i2c_chunk_sequencer_chk chk_i (
  .clk(clk), .rstN(rstN), .done(done), .errCode(errCode),
  .engCmdValid(engCmdValid), .engCmdChain(engCmdChain),
  .engCmdRepStart(engCmdRepStart), .engCmdRead(engCmdRead),
  .engBufWrite(engBufWrite), .engBufRead(engBufRead),
  .engFlush(engFlush), .engBusFree(engBusFree), .engAbort(engAbort)
);

// File: tb/i2c_chunk_sequencer_test.sv
module i2c_chunk_sequencer_test;

  localparam int TMO = 16;
  localparam int NCASE = 18;

  typedef struct packed {
    logic [7:0] len;
    logic       rd;
    logic [9:0] addr;
    logic       ten;
    logic       comb;
    logic       free;
    logic [2:0] shortAt;
    logic [7:0] delay;
  } case_t;

  // len, rd, addr, ten, comb, busFree, shortAt (piece index+1, 0 none), response delay
  localparam case_t CASES [NCASE] = '{
    '{8'd9,  1'b0, 10'h050, 1'b0, 1'b0, 1'b1, 3'd0, 8'd3},
    '{8'd4,  1'b1, 10'h02A, 1'b0, 1'b0, 1'b1, 3'd0, 8'd2},
    '{8'd1,  1'b0, 10'h2B5, 1'b1, 1'b0, 1'b1, 3'd0, 8'd1},
    '{8'd6,  1'b0, 10'h050, 1'b0, 1'b1, 1'b1, 3'd0, 8'd2},
    '{8'd5,  1'b1, 10'h050, 1'b0, 1'b0, 1'b0, 3'd0, 8'd2},
    '{8'd3,  1'b0, 10'h050, 1'b0, 1'b1, 1'b1, 3'd0, 8'd1},
    '{8'd2,  1'b1, 10'h051, 1'b0, 1'b0, 1'b1, 3'd0, 8'd1},
    '{8'd0,  1'b0, 10'h010, 1'b0, 1'b0, 1'b1, 3'd0, 8'd1},
    '{8'd2,  1'b0, 10'h080, 1'b0, 1'b0, 1'b1, 3'd0, 8'd1},
    '{8'd3,  1'b0, 10'h010, 1'b0, 1'b0, 1'b0, 3'd0, 8'd1},
    '{8'd10, 1'b1, 10'h033, 1'b0, 1'b0, 1'b1, 3'd2, 8'd2},
    '{8'd7,  1'b0, 10'h033, 1'b0, 1'b0, 1'b1, 3'd2, 8'd1},
    '{8'd3,  1'b1, 10'h044, 1'b0, 1'b1, 1'b1, 3'd1, 8'd1},
    '{8'd5,  1'b0, 10'h044, 1'b0, 1'b0, 1'b1, 3'd0, 8'd16},
    '{8'd5,  1'b0, 10'h044, 1'b0, 1'b0, 1'b1, 3'd0, 8'd17},
    '{8'd16, 1'b1, 10'h3FF, 1'b1, 1'b0, 1'b1, 3'd0, 8'd1},
    '{8'd2,  1'b0, 10'h044, 1'b1, 1'b1, 1'b1, 3'd0, 8'd1},
    '{8'd1,  1'b0, 10'h044, 1'b0, 1'b0, 1'b1, 3'd0, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] reqLen = '0;
  logic reqRead = 1'b0;
  logic [9:0] reqAddr = '0;
  logic reqTenBit = 1'b0;
  logic reqCombined = 1'b0;
  logic [7:0] txByte;
  logic txPop, rxPush, done;
  logic [7:0] rxByte;
  logic [2:0] errCode;
  logic engFlush, engAddrLoad, engAddrMode, engBufWrite, engBufRead;
  logic [7:0] engAddrLo, engAddrHi, engBufWData, engBufRData;
  logic engCmdValid, engCmdRead, engCmdChain, engCmdRepStart, engAbort;
  logic [1:0] engCmdCount;
  logic engDone = 1'b0;
  logic [2:0] engXferCount = '0;
  logic engBusFree = 1'b1;

  always #5 clk = ~clk;

  i2c_chunk_sequencer #(.LEN_W(8), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rstN(rstN), .start(start), .reqLen(reqLen), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqTenBit(reqTenBit), .reqCombined(reqCombined),
    .txByte(txByte), .txPop(txPop), .rxByte(rxByte), .rxPush(rxPush),
    .done(done), .errCode(errCode), .engFlush(engFlush), .engAddrLoad(engAddrLoad),
    .engAddrLo(engAddrLo), .engAddrHi(engAddrHi), .engAddrMode(engAddrMode),
    .engBufWrite(engBufWrite), .engBufWData(engBufWData), .engBufRead(engBufRead),
    .engBufRData(engBufRData), .engCmdValid(engCmdValid), .engCmdCount(engCmdCount),
    .engCmdRead(engCmdRead), .engCmdChain(engCmdChain), .engCmdRepStart(engCmdRepStart),
    .engDone(engDone), .engXferCount(engXferCount), .engAbort(engAbort),
    .engBusFree(engBusFree)
  );

  int checks = 0;
  int fails = 0;

  // logs, filled at negedges
  int nCmd, nWr, nRd, nAbort, nFlush, nAddrLd;
  int cmdCnt [64];
  int cmdChn [64];
  int cmdRep [64];
  int cmdDir [64];
  int wrLog [64];
  int rdLog [64];
  int aLo, aHi, aMode;

  assign txByte      = 8'h10 + 8'(nWr);
  assign engBufRData = 8'hC0 + 8'(nRd);

  always @(negedge clk) begin
    if (engCmdValid && nCmd < 64) begin
      cmdCnt[nCmd] = int'(engCmdCount);
      cmdChn[nCmd] = int'(engCmdChain);
      cmdRep[nCmd] = int'(engCmdRepStart);
      cmdDir[nCmd] = int'(engCmdRead);
      nCmd++;
    end
    if (engBufWrite && nWr < 64) begin wrLog[nWr] = int'(engBufWData); nWr++; end
    if (rxPush && nRd < 64) begin rdLog[nRd] = int'(rxByte); nRd++; end
    if (engAbort) nAbort++;
    if (engFlush) nFlush++;
    if (engAddrLoad) begin
      nAddrLd++;
      aLo = int'(engAddrLo); aHi = int'(engAddrHi); aMode = int'(engAddrMode);
    end
  end

  // engine responder
  int respDelay = 1;
  int respShort = 0;
  int respIdx = 0;
  bit respBusy = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (engCmdValid) begin
        int want;
        respBusy = 1'b1;
        respIdx++;
        want = int'(engCmdCount) + 1;
        repeat (respDelay) @(negedge clk);
        engXferCount = (respIdx == respShort) ? 3'(want - 1) : 3'(want);
        engDone = 1'b1;
        @(negedge clk);
        engDone = 1'b0;
        respBusy = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=0 expected=1");
    summary();
    $finish;
  end

  // independent model of the combined-run state
  bit mRun = 1'b0;
  logic [9:0] mRunAddr = '0;
  bit mRunTen = 1'b0;

  initial begin
    // reset state, R10
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && errCode == 3'd0, "R10", "done/err in reset", int'(done) + int'(errCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!done && !engCmdValid && !engFlush && !txPop && !rxPush && !engAbort && !engAddrLoad,
        "R10", "strobes idle after reset", int'(engCmdValid) + int'(engFlush) + int'(txPop), 0);
    chk(errCode == 3'd0, "R10", "errCode after reset", int'(errCode), 0);

    for (int c = 0; c < NCASE; c++) begin
      case_t tc;
      int n, eErr, eCmd, eWr, eRd, eAbort, eFlush, waitCyc;
      bit argBadM, cont, cntOk, chnOk, repOk, dirOk, wrOk, rdOk;
      string tagErr;
      tc = CASES[c];

      // expectations
      n = (int'(tc.len) + 3) / 4;
      argBadM = (tc.len == 0) || (!tc.ten && tc.addr > 10'h07F) ||
                (mRun && (tc.addr != mRunAddr || tc.ten != mRunTen));
      cont = mRun && !argBadM;
      eCmd = 0; eWr = 0; eRd = 0; eAbort = 0; eFlush = 0;
      if (argBadM) begin
        eErr = 1; tagErr = "R6";
      end else if (!mRun && !tc.free) begin
        eErr = 2; tagErr = "R7";
      end else begin
        eFlush = cont ? 0 : 1;
        if (int'(tc.delay) > TMO) begin
          eErr = 4; tagErr = "R9"; eCmd = 1; eAbort = 1;
          eWr = tc.rd ? 0 : ((tc.len > 4) ? 4 : int'(tc.len));
        end else if (tc.shortAt != 0) begin
          eErr = 3; tagErr = "R8"; eCmd = int'(tc.shortAt);
          eAbort = (int'(tc.shortAt) < n || tc.comb) ? 1 : 0;
          if (tc.rd) eRd = (int'(tc.len) < 4 * (eCmd - 1)) ? int'(tc.len) : 4 * (eCmd - 1);
          else       eWr = (int'(tc.len) < 4 * eCmd) ? int'(tc.len) : 4 * eCmd;
        end else begin
          eErr = 0; tagErr = "R1"; eCmd = n;
          if (tc.rd) eRd = int'(tc.len); else eWr = int'(tc.len);
        end
      end

      // clear logs and set stimulus
      nCmd = 0; nWr = 0; nRd = 0; nAbort = 0; nFlush = 0; nAddrLd = 0;
      respIdx = 0; respDelay = int'(tc.delay); respShort = int'(tc.shortAt);
      engBusFree = tc.free;
      reqLen = tc.len; reqRead = tc.rd; reqAddr = tc.addr;
      reqTenBit = tc.ten; reqCombined = tc.comb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitCyc = 0;
      while (!done && waitCyc < 2000) begin
        @(negedge clk);
        waitCyc++;
      end

      chk(done == 1'b1, "R10", $sformatf("case %0d done seen", c), int'(done), 1);
      chk(int'(errCode) == eErr, tagErr, $sformatf("case %0d errCode", c), int'(errCode), eErr);
      chk(nCmd == eCmd, "R1", $sformatf("case %0d command count", c), nCmd, eCmd);

      cntOk = 1; chnOk = 1; repOk = 1; dirOk = 1;
      for (int k = 0; k < nCmd && k < eCmd; k++) begin
        int rem, pc;
        rem = int'(tc.len) - 4 * k;
        pc = (rem > 4) ? 4 : rem;
        if (cmdCnt[k] != pc - 1) cntOk = 0;
        if (cmdChn[k] != ((k < n - 1) ? 1 : 0)) chnOk = 0;
        if (cmdRep[k] != ((k == n - 1 && tc.comb) ? 1 : 0)) repOk = 0;
        if (cmdDir[k] != int'(tc.rd)) dirOk = 0;
      end
      if (eCmd > 0) begin
        chk(cntOk, "R1", $sformatf("case %0d count fields", c), cmdCnt[0], (tc.len > 4) ? 3 : int'(tc.len) - 1);
        chk(chnOk, "R2", $sformatf("case %0d chain flags", c), cmdChn[0], (n > 1) ? 1 : 0);
        chk(repOk, "R3", $sformatf("case %0d repeated-start flags", c), cmdRep[nCmd > 0 ? nCmd - 1 : 0], int'(tc.comb));
        chk(dirOk, "R4", $sformatf("case %0d command direction", c), cmdDir[0], int'(tc.rd));
      end

      wrOk = (nWr == eWr);
      for (int i = 0; i < nWr && i < eWr; i++) if (wrLog[i] != 16 + i) wrOk = 0;
      chk(wrOk, "R4", $sformatf("case %0d written bytes", c), nWr, eWr);
      rdOk = (nRd == eRd);
      for (int i = 0; i < nRd && i < eRd; i++) if (rdLog[i] != 192 + i) rdOk = 0;
      chk(rdOk, "R4", $sformatf("case %0d read bytes", c), nRd, eRd);

      chk(nAbort == eAbort, (eErr == 4) ? "R9" : "R8", $sformatf("case %0d aborts", c), nAbort, eAbort);
      chk(nFlush == eFlush && nAddrLd == eFlush, "R7", $sformatf("case %0d flush/addr loads", c), nFlush, eFlush);

      if (eFlush == 1) begin
        int eLo, eHi;
        eLo = tc.ten ? int'(tc.addr[7:0]) : int'({tc.addr[6:0], 1'b0});
        eHi = tc.ten ? (8'hF0 | ((int'(tc.addr) >> 7) & 6)) : 0;
        chk(aLo == eLo && aHi == eHi && aMode == int'(tc.ten), "R5",
            $sformatf("case %0d address bytes", c), aLo * 256 + aHi, eLo * 256 + eHi);
      end

      // model run update
      if (eErr == 0 && tc.comb) begin
        mRun = 1'b1; mRunAddr = tc.addr; mRunTen = tc.ten;
      end else begin
        mRun = 1'b0;
      end

      // let any late engine answer drain before the next case
      while (respBusy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(!done, "R10", $sformatf("case %0d single done pulse", c), int'(done), 0);
    end

    summary();
    $finish;
  end

endmodule